// File: doc/BRIEF.md
# Slot-Table Memory Bandwidth Arbiter

This block shares one memory port among up to fifteen clients by time division. A slot pointer walks a programmable table of 64 entries. Each entry names the client that owns that slot. When the pointer stops on a slot, the owner gets the port if it is requesting. Otherwise the slot goes to the lowest-numbered client that is requesting. If no client requests, the slot is skipped without a grant.

Two independent tables are held, one per memory region. A region-select input picks which table decides each slot. Software fills the tables one entry at a time and sets a maximum burst length for each client. A granted client keeps the port for that many beats plus one, or until it drops its request. The grant then ends and the pointer moves on.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, `gnt` is all zero and `slot_idx` is 0. Every table entry in both regions holds the unowned code 15. Every client's burst length register holds 3.
- R2: In an arbitration cycle, if the owner named by the selected table entry at `slot_idx` is requesting, that owner is granted, even when lower-numbered clients are requesting too.
- R3: If the owner is not requesting, or the entry holds a code of 15 or above (unowned), the lowest-index requesting client is granted.
- R4: If no client requests in an arbitration cycle, no grant is issued and `slot_idx` advances by one on that edge.
- R5: A grant is registered. It appears on the edge after the arbitration cycle. With the request held, it stays asserted for (burst length + 1) cycles. It then drops for at least one cycle, and `slot_idx` advances by one on the releasing edge.
- R6: If the granted client drops its request, the grant is released on the next edge, and `slot_idx` advances.
- R7: `slot_idx` wraps from 63 to 0.
- R8: `region_sel` chooses which of the two tables is consulted in an arbitration cycle. A write with `tbl_region`=1 leaves the region-0 table unchanged.
- R9: A table write during a grant does not alter or cut short that grant. The new entry is used from the next arbitration on that slot.
- R10: `gnt` is one-hot or zero in every cycle. It never switches from one client to another without an all-zero cycle in between.
- R11: A burst length write for a client takes effect from that client's next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_sel | input | 1 | Table used for arbitration (0 or 1) |
| req | input | 15 | Per-client request |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_region | input | 1 | Region of the table entry being written |
| tbl_slot | input | 6 | Slot index being written |
| tbl_owner | input | 4 | Owner code written (15 = unowned) |
| bst_we | input | 1 | Burst length write strobe |
| bst_client | input | 4 | Client whose burst length is written |
| bst_len | input | 4 | Burst length; a grant lasts this value plus one beats |
| gnt | output | 15 | Registered one-hot grant |
| slot_idx | output | 6 | Current slot pointer |

## Verification
An arbitration decision made from `req` in a cycle appears on `gnt` one edge later. Idle slots and grant releases move `slot_idx` on the same edge that decides them. A table or burst write lands one edge after its strobe. The bench drives inputs on the falling edge and samples both outputs on the next falling edge. It keeps a model of the pointer, updated one step per edge by these rules. Each table entry is written two edges before the pointer reaches it, so every arbitration reads a settled entry.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    localparam int DEF_CLIENTS   = 15;
    localparam int DEF_SLOTS     = 64;
    localparam int DEF_BURST_W   = 4;
    localparam int DEF_BURST_RST = 3;
    localparam int NUM_REGIONS   = 2;

    typedef enum logic {
        PH_PICK = 1'b0,
        PH_HOLD = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/slot_table.sv
module slot_table #(
    parameter int N_SLOTS   = 64,
    parameter int N_REGIONS = 2,
    parameter int OWN_W     = 4,
    localparam int PTR_W    = $clog2(N_SLOTS),
    localparam int REG_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wr_region,
    input  logic [PTR_W-1:0] wr_slot,
    input  logic [OWN_W-1:0] wr_owner,
    input  logic [REG_W-1:0] rd_region,
    input  logic [PTR_W-1:0] rd_slot,
    output logic [OWN_W-1:0] rd_owner
);

    logic [OWN_W-1:0] rd_bank [N_REGIONS];

    for (genvar r = 0; r < N_REGIONS; r++) begin : g_bank
        typedef struct packed {
            logic [N_SLOTS-1:0][OWN_W-1:0] ent;
        } bank_t;

        bank_t bank_d, bank_q;

        always_comb begin
            bank_d = bank_q;
            if (we && (wr_region == REG_W'(r))) begin
                bank_d.ent[wr_slot] = wr_owner;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= '1;
            end else begin
                bank_q <= bank_d;
            end
        end

        assign rd_bank[r] = bank_q.ent[rd_slot];
    end

    always_comb begin
        rd_owner = rd_bank[0];
        for (int r = 1; r < N_REGIONS; r++) begin
            if (rd_region == REG_W'(r)) begin
                rd_owner = rd_bank[r];
            end
        end
    end

endmodule

// File: rtl/burst_cfg.sv
module burst_cfg #(
    parameter int N_CLIENTS = 15,
    parameter int BURST_W   = 4,
    parameter int BURST_RST = 3,
    localparam int IDX_W    = $clog2(N_CLIENTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   wr_client,
    input  logic [BURST_W-1:0] wr_len,
    input  logic [IDX_W-1:0]   rd_client,
    output logic [BURST_W-1:0] rd_len
);

    typedef struct packed {
        logic [N_CLIENTS-1:0][BURST_W-1:0] len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && (int'(wr_client) < N_CLIENTS)) begin
            cfg_d.len[wr_client] = wr_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CLIENTS; c++) begin
                cfg_q.len[c] <= BURST_W'(BURST_RST);
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_len = cfg_q.len[rd_client];

endmodule

// File: rtl/low_pick.sv
module low_pick #(
    parameter int N_CLIENTS = 15,
    localparam int IDX_W    = $clog2(N_CLIENTS)
) (
    input  logic [N_CLIENTS-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        idx = '0;
        for (int i = N_CLIENTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int N_CLIENTS = DEF_CLIENTS,
    parameter int N_SLOTS   = DEF_SLOTS,
    parameter int BURST_W   = DEF_BURST_W,
    parameter int BURST_RST = DEF_BURST_RST,
    localparam int PTR_W    = $clog2(N_SLOTS),
    localparam int IDX_W    = $clog2(N_CLIENTS),
    localparam int OWN_W    = $clog2(N_CLIENTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 region_sel,
    input  logic [N_CLIENTS-1:0] req,
    input  logic                 tbl_we,
    input  logic                 tbl_region,
    input  logic [PTR_W-1:0]     tbl_slot,
    input  logic [OWN_W-1:0]     tbl_owner,
    input  logic                 bst_we,
    input  logic [IDX_W-1:0]     bst_client,
    input  logic [BURST_W-1:0]   bst_len,
    output logic [N_CLIENTS-1:0] gnt,
    output logic [PTR_W-1:0]     slot_idx
);

    localparam int OWN_SPAN = 1 << OWN_W;

    typedef struct packed {
        arb_phase_e             phase;
        logic [N_CLIENTS-1:0]   gnt;
        logic [IDX_W-1:0]       who;
        logic [BURST_W-1:0]     cnt;
        logic [BURST_W-1:0]     lim;
        logic [PTR_W-1:0]       ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [OWN_W-1:0]    slot_owner;
    logic [OWN_SPAN-1:0] req_wide;
    logic                owner_ok;
    logic                low_any;
    logic [IDX_W-1:0]    low_idx;
    logic                win_any;
    logic [IDX_W-1:0]    win_idx;
    logic [BURST_W-1:0]  win_len;
    logic [PTR_W-1:0]    ptr_inc;

    slot_table #(
        .N_SLOTS   (N_SLOTS),
        .N_REGIONS (NUM_REGIONS),
        .OWN_W     (OWN_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tbl_we),
        .wr_region (tbl_region),
        .wr_slot   (tbl_slot),
        .wr_owner  (tbl_owner),
        .rd_region (region_sel),
        .rd_slot   (st_q.ptr),
        .rd_owner  (slot_owner)
    );

    burst_cfg #(
        .N_CLIENTS (N_CLIENTS),
        .BURST_W   (BURST_W),
        .BURST_RST (BURST_RST)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bst_we),
        .wr_client (bst_client),
        .wr_len    (bst_len),
        .rd_client (win_idx),
        .rd_len    (win_len)
    );

    low_pick #(
        .N_CLIENTS (N_CLIENTS)
    ) u_pick (
        .req (req),
        .any (low_any),
        .idx (low_idx)
    );

    // Owner claim: unowned codes (>= N_CLIENTS) never win the slot.
    always_comb begin
        req_wide = OWN_SPAN'(req);
        owner_ok = (int'(slot_owner) < N_CLIENTS) && req_wide[slot_owner];
        win_any  = owner_ok || low_any;
        win_idx  = owner_ok ? IDX_W'(slot_owner) : low_idx;
        ptr_inc  = (st_q.ptr == PTR_W'(N_SLOTS - 1)) ? '0 : st_q.ptr + 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_PICK: begin
                if (win_any) begin
                    st_d.phase = PH_HOLD;
                    st_d.gnt   = N_CLIENTS'(1) << win_idx;
                    st_d.who   = win_idx;
                    st_d.cnt   = '0;
                    st_d.lim   = win_len;
                end else begin
                    st_d.ptr = ptr_inc;
                end
            end
            PH_HOLD: begin
                if (!req[st_q.who] || (st_q.cnt == st_q.lim)) begin
                    st_d.phase = PH_PICK;
                    st_d.gnt   = '0;
                    st_d.ptr   = ptr_inc;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_PICK, gnt: '0, who: '0, cnt: '0, lim: '0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt      = st_q.gnt;
    assign slot_idx = st_q.ptr;

    // R10: never more than one client holds the port
    p_gnt_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R10: a grant never hops directly to another client
    p_no_hop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (!(|gnt) || $stable(gnt)));

    // R2: a fresh grant goes to a client that requested in the deciding cycle
    p_gnt_to_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_PICK) && (|req)) |=> (|($past(req) & gnt)));

    // R4: an arbitration cycle with no request consumes the slot
    p_idle_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_PICK) && !(|req)) |=>
            ((gnt == '0) && (slot_idx != $past(slot_idx))));

    // R5: the beat counter never runs past the programmed limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> (st_q.cnt <= st_q.lim));

    // R5/R6: a release advances the pointer by exactly one
    p_release_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> ((|gnt) ||
            (slot_idx == (($past(slot_idx) == PTR_W'(N_SLOTS - 1)) ? '0 : PTR_W'($past(slot_idx) + 1'b1)))));

    // R7: pointer only holds or steps forward by one with wrap
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((slot_idx == $past(slot_idx)) ||
            (slot_idx == (($past(slot_idx) == PTR_W'(N_SLOTS - 1)) ? '0 : PTR_W'($past(slot_idx) + 1'b1)))));

endmodule

// File: tb/tb_slot_arbiter.sv
module tb_slot_arbiter;

    localparam int NC = 15;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        region_sel = 1'b0;
    logic [14:0] req = '0;
    logic        tbl_we = 1'b0;
    logic        tbl_region = 1'b0;
    logic [5:0]  tbl_slot = '0;
    logic [3:0]  tbl_owner = '0;
    logic        bst_we = 1'b0;
    logic [3:0]  bst_client = '0;
    logic [3:0]  bst_len = '0;
    logic [14:0] gnt;
    logic [5:0]  slot_idx;

    int total = 0;
    int bad = 0;
    int exp_ptr = 0;
    int wd = 0;

    always #4 clk = ~clk;

    slot_arbiter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .region_sel (region_sel),
        .req        (req),
        .tbl_we     (tbl_we),
        .tbl_region (tbl_region),
        .tbl_slot   (tbl_slot),
        .tbl_owner  (tbl_owner),
        .bst_we     (bst_we),
        .bst_client (bst_client),
        .bst_len    (bst_len),
        .gnt        (gnt),
        .slot_idx   (slot_idx)
    );

    typedef struct packed {
        logic [3:0]  own;
        logic [14:0] rq;
        logic [14:0] ex;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd4,  15'h0010, 15'h0010},
        '{4'd4,  15'h0013, 15'h0010},
        '{4'd4,  15'h0006, 15'h0002},
        '{4'd15, 15'h4100, 15'h0100},
        '{4'd9,  15'h0000, 15'h0000},
        '{4'd14, 15'h4000, 15'h4000},
        '{4'd0,  15'h7FFF, 15'h0001},
        '{4'd14, 15'h7FFF, 15'h4000},
        '{4'd3,  15'h4400, 15'h0400},
        '{4'd12, 15'h0000, 15'h0000}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bump();
        exp_ptr = (exp_ptr + 1) % NS;
    endtask

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // write an entry two slots ahead, then idle until the pointer sits on it
    task automatic prep_slot(input logic rg, input logic [3:0] own);
        tbl_we = 1'b1; tbl_region = rg;
        tbl_slot = 6'((exp_ptr + 2) % NS); tbl_owner = own;
        step(); bump();
        tbl_we = 1'b0;
        step(); bump();
    endtask

    task automatic set_burst(input logic [3:0] c, input logic [3:0] l);
        bst_we = 1'b1; bst_client = c; bst_len = l;
        step(); bump();
        bst_we = 1'b0;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #20;
        @(negedge clk);
        check(gnt, 0, "R1 gnt in reset");
        check(slot_idx, 0, "R1 slot in reset");

        // R1/R3/R5: unowned slot 0, default burst 3 -> 4 grant cycles to client 2
        req = 15'h0004;
        rst_n = 1'b1;
        step();
        check(gnt, 15'h0004, "R1/R3 unowned fallback after reset");
        check(slot_idx, 0, "R5 pointer holds during grant");
        for (int k = 0; k < 3; k++) begin
            step();
            check(gnt, 15'h0004, "R1/R5 default burst hold");
        end
        step();
        check(gnt, 0, "R5 release after len+1");
        exp_ptr = 1;
        check(slot_idx, exp_ptr, "R5 pointer advances at release");
        req = '0;
        step(); bump();

        // R11: burst length 0 for every client
        for (int c = 0; c < NC; c++) begin
            set_burst(4'(c), 4'd0);
        end

        // vector table: owner claim and fallback with one-beat bursts
        for (int v = 0; v < 10; v++) begin
            prep_slot(1'b0, VECS[v].own);
            req = VECS[v].rq;
            step();
            check(gnt, VECS[v].ex, $sformatf("R2/R3/R4/R10 vector %0d", v));
            req = '0;
            if (VECS[v].ex != '0) begin
                step();
                check(gnt, 0, "R5 single beat release");
            end
            bump();
            check(slot_idx, exp_ptr, $sformatf("R4/R5 pointer vector %0d", v));
        end

        // R11: client 6 length 1 -> two grant cycles
        set_burst(4'd6, 4'd1);
        prep_slot(1'b0, 4'd6);
        req = 15'h0040;
        step();
        check(gnt, 15'h0040, "R11 new length cycle 1");
        step();
        check(gnt, 15'h0040, "R11 new length cycle 2");
        step(); bump();
        check(gnt, 0, "R11 released after 2");
        req = '0;
        step(); bump();

        // R6/R9: long burst, table rewritten mid-grant, early drop
        set_burst(4'd5, 4'd7);
        prep_slot(1'b0, 4'd5);
        req = 15'h0220;
        step();
        check(gnt, 15'h0020, "R2 owner 5 granted");
        tbl_we = 1'b1; tbl_region = 1'b0; tbl_slot = 6'(exp_ptr); tbl_owner = 4'd9;
        step();
        tbl_we = 1'b0;
        check(gnt, 15'h0020, "R9 grant kept after table write");
        step();
        check(gnt, 15'h0020, "R9 grant kept");
        req = 15'h0200;
        step(); bump();
        check(gnt, 0, "R6 early release on drop");
        check(slot_idx, exp_ptr, "R6 pointer after early release");
        req = '0;
        step(); bump();

        // R8: region 1 entry owner 7, region 0 entry owner 3 on the same slot
        tbl_we = 1'b1; tbl_region = 1'b1; tbl_slot = 6'((exp_ptr + 3) % NS); tbl_owner = 4'd7;
        step(); bump();
        tbl_region = 1'b0; tbl_slot = 6'((exp_ptr + 2) % NS); tbl_owner = 4'd3;
        step(); bump();
        tbl_we = 1'b0;
        step(); bump();
        region_sel = 1'b1;
        req = 15'h0088;
        step();
        check(gnt, 15'h0080, "R8 region 1 owner");
        req = '0;
        step(); bump();
        region_sel = 1'b0;

        // R8: region-0 entry at a fresh slot still unchanged by region-1 write
        tbl_we = 1'b1; tbl_region = 1'b1; tbl_slot = 6'((exp_ptr + 2) % NS); tbl_owner = 4'd7;
        step(); bump();
        tbl_we = 1'b0;
        step(); bump();
        req = 15'h0088;
        step();
        check(gnt, 15'h0008, "R8 region 0 untouched by region 1 write");
        req = '0;
        step(); bump();

        // R7: wrap from 63 to 0
        while (exp_ptr != NS - 1) begin
            step(); bump();
        end
        check(slot_idx, 63, "R7 pointer at top");
        step(); bump();
        check(slot_idx, 0, "R7 pointer wrapped");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule